// File: doc/BRIEF.md
# Mode-Width Register-Pair Adder

This block performs the arithmetic of the register-pair add instructions. The destination is either the HL pair or an index register. The source is an external register pair, the destination itself, or the stack pointer. The datapath is 16 bits wide in compatibility mode and 24 bits wide in long-address mode. A per-instruction override code can force either width for one operation.

The surrounding core reads the operands from its register file and presents them together with the carry flag, a with-carry select and the width controls. Register storage stays outside this block, with one exception: when the source is the stack pointer, the block picks between the short and the long stack pointer itself. The result appears one cycle later, masked to the active width. It comes with a flag byte and a flag update mask, and the register file uses the mask to merge the new flags into F.

The plain add updates only the half-carry, subtract and carry flags. The with-carry form also produces sign, zero and overflow. The half-carry always comes from bit 11, whatever the width.

Top module: `mwadd_top`

## Requirements
- R1: The active width is 24 bits when `ovr_code` is 2'b10, 16 bits when it is 2'b01, and follows `long_mode` (1 = 24 bits) when it is 2'b00 or 2'b11. `out_long` reports the width that was used.
- R2: `result` equals (destination + source + effective carry) modulo 2^width. In 16-bit operation, bits 23:16 of `result` are zero and bits 23:16 of every operand are ignored.
- R3: Flag C (bit 0 of `flags`) is the carry out of the top bit of the active width.
- R4: Flag H (bit 4 of `flags`) is the carry out of bit 11 at both widths.
- R5: When `with_carry` is 0, `flag_mask` is 8'h13, so only H, N and C are updated. Bits 7, 6 and 2 of `flags` read 0.
- R6: When `with_carry` is 1, `flag_mask` is 8'hD7. S (bit 7) is the top result bit of the active width, and Z (bit 6) is set when the masked result is zero.
- R7: When `with_carry` is 1, P/V (bit 2) is set on two's-complement overflow at the active width.
- R8: N (bit 1) is always 0. Flag bits 5 and 3 are always 0.
- R9: `carry_in` enters the sum only when `with_carry` is 1.
- R10: With `src_sel` = 2'b10, the source is `sp_long` at 24 bits and `sp_short`, zero-extended, at 16 bits. `src_pair` has no effect.
- R11: With `src_sel` = 2'b01, the source is the destination itself, so the destination is doubled. `src_pair` has no effect. `src_sel` 2'b00 and 2'b11 both select `src_pair`.
- R12: A request with `with_carry` = 1 and `dst_index` = 1 is rejected, and `out_valid` stays low in the following cycle.
- R13: An accepted request raises `out_valid` for exactly the next cycle, with its outputs. After reset, `out_valid`, `result`, `flags` and `flag_mask` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| dst_val | input | 24 | Destination operand |
| src_pair | input | 24 | External register-pair source |
| sp_long | input | 24 | Long stack pointer |
| sp_short | input | 16 | Short stack pointer |
| src_sel | input | 2 | Source select: 00/11 pair, 01 self, 10 stack |
| dst_index | input | 1 | Destination is an index register |
| with_carry | input | 1 | Selects the add-with-carry form |
| carry_in | input | 1 | Incoming C flag |
| long_mode | input | 1 | Current address mode (1 = long) |
| ovr_code | input | 2 | Per-instruction width override |
| out_valid | output | 1 | Result valid |
| out_long | output | 1 | Result was computed at 24 bits |
| result | output | 24 | Masked sum |
| flags | output | 8 | S7 Z6 H4 PV2 N1 C0 |
| flag_mask | output | 8 | Flag bits to write back |

## Verification
The bench targets the signed boundaries at each width: 0x7FFF+1 and 0x8000+0x8000 at 16 bits, 0x7FFFFF+1 and 0x800000+0x800000 at 24 bits. A design that detects overflow or carry at a fixed bit position would report the wrong P/V or C at one of the two widths. Doubling, stack-pointer selection with both overrides, and a carry-in presented to the plain add are all driven. A wrong source multiplexer, an unmasked upper byte, or a carry leaking into the plain add each shows up as a result mismatch. The bench also sends an add-with-carry aimed at an index register, and a design that accepts it produces an unexpected result strobe.

// File: rtl/mwa_pkg.sv
package mwa_pkg;
  // Flag byte layout consumed by the register file
  localparam int FLG_S  = 7;
  localparam int FLG_Z  = 6;
  localparam int FLG_H  = 4;
  localparam int FLG_PV = 2;
  localparam int FLG_N  = 1;
  localparam int FLG_C  = 0;

  typedef enum logic [1:0] {
    SRC_PAIR     = 2'b00,
    SRC_SELF     = 2'b01,
    SRC_STACK    = 2'b10,
    SRC_PAIR_ALT = 2'b11
  } src_sel_e;

  typedef enum logic [1:0] {
    OVR_NONE     = 2'b00,
    OVR_SHORT    = 2'b01,
    OVR_LONG     = 2'b10,
    OVR_NONE_ALT = 2'b11
  } ovr_e;

  // Effective width decision: override wins, otherwise the mode bit
  function automatic logic pick_long(input logic mode, input logic [1:0] ovr);
    case (ovr)
      OVR_SHORT: pick_long = 1'b0;
      OVR_LONG:  pick_long = 1'b1;
      default:   pick_long = mode;
    endcase
  endfunction

  function automatic logic [7:0] mask_for(input logic adc);
    logic [7:0] m;
    m = '0;
    m[FLG_H] = 1'b1;
    m[FLG_N] = 1'b1;
    m[FLG_C] = 1'b1;
    if (adc) begin
      m[FLG_S]  = 1'b1;
      m[FLG_Z]  = 1'b1;
      m[FLG_PV] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/mwa_width_sel.sv
module mwa_width_sel #(
  parameter int W_LONG  = 24,
  parameter int W_SHORT = 16
) (
  input  logic              long_mode,
  input  logic [1:0]        ovr_code,
  output logic              is_long,
  output logic [W_LONG-1:0] keep_mask
);
  import mwa_pkg::*;
  localparam int W_GAP = W_LONG - W_SHORT;

  assign is_long   = pick_long(long_mode, ovr_code);
  assign keep_mask = is_long ? {W_LONG{1'b1}} : {{W_GAP{1'b0}}, {W_SHORT{1'b1}}};
endmodule

// File: rtl/mwa_opsel.sv
module mwa_opsel #(
  parameter int W_LONG  = 24,
  parameter int W_SHORT = 16
) (
  input  logic [W_LONG-1:0]  dst_val,
  input  logic [W_LONG-1:0]  src_pair,
  input  logic [W_LONG-1:0]  sp_long,
  input  logic [W_SHORT-1:0] sp_short,
  input  logic [1:0]         src_sel,
  input  logic               is_long,
  input  logic [W_LONG-1:0]  keep_mask,
  output logic [W_LONG-1:0]  op_a,
  output logic [W_LONG-1:0]  op_b
);
  import mwa_pkg::*;
  localparam int W_GAP = W_LONG - W_SHORT;

  logic [W_LONG-1:0] stack_val;
  logic [W_LONG-1:0] raw_b;

  // Stack pointer choice follows the effective width
  assign stack_val = is_long ? sp_long : {{W_GAP{1'b0}}, sp_short};

  always_comb begin
    case (src_sel)
      SRC_SELF:  raw_b = dst_val;
      SRC_STACK: raw_b = stack_val;
      default:   raw_b = src_pair;
    endcase
  end

  assign op_a = dst_val & keep_mask;
  assign op_b = raw_b & keep_mask;
endmodule

// File: rtl/mwa_arith.sv
module mwa_arith #(
  parameter int W_LONG   = 24,
  parameter int W_SHORT  = 16,
  parameter int HALF_BIT = 11
) (
  input  logic [W_LONG-1:0] op_a,
  input  logic [W_LONG-1:0] op_b,
  input  logic              cin,
  input  logic              is_long,
  input  logic [W_LONG-1:0] keep_mask,
  output logic [W_LONG-1:0] sum,
  output logic              carry_out,
  output logic              half_carry,
  output logic              sign_ovf,
  output logic              res_msb,
  output logic              res_zero
);
  logic [W_LONG:0] raw;
  logic            a_top, b_top;

  function automatic logic [W_LONG:0] wide_add(input logic [W_LONG-1:0] a,
                                               input logic [W_LONG-1:0] b,
                                               input logic c);
    return {1'b0, a} + {1'b0, b} + {{W_LONG{1'b0}}, c};
  endfunction

  function automatic logic top_bit(input logic [W_LONG-1:0] v, input logic lng);
    return lng ? v[W_LONG-1] : v[W_SHORT-1];
  endfunction

  assign raw        = wide_add(op_a, op_b, cin);
  assign sum        = raw[W_LONG-1:0] & keep_mask;
  assign carry_out  = is_long ? raw[W_LONG] : raw[W_SHORT];
  // carry out of HALF_BIT equals the carry into the bit above it
  assign half_carry = op_a[HALF_BIT+1] ^ op_b[HALF_BIT+1] ^ raw[HALF_BIT+1];
  assign a_top      = top_bit(op_a, is_long);
  assign b_top      = top_bit(op_b, is_long);
  assign res_msb    = top_bit(sum, is_long);
  assign sign_ovf   = (a_top == b_top) && (res_msb != a_top);
  assign res_zero   = (sum == '0);
endmodule

// File: rtl/mwa_flagpack.sv
module mwa_flagpack (
  input  logic       with_carry,
  input  logic       half_carry,
  input  logic       carry_out,
  input  logic       sign_ovf,
  input  logic       res_msb,
  input  logic       res_zero,
  output logic [7:0] flags,
  output logic [7:0] flag_mask
);
  import mwa_pkg::*;

  always_comb begin
    flags        = '0;
    flags[FLG_H] = half_carry;
    flags[FLG_C] = carry_out;
    flags[FLG_N] = 1'b0;
    if (with_carry) begin
      flags[FLG_S]  = res_msb;
      flags[FLG_Z]  = res_zero;
      flags[FLG_PV] = sign_ovf;
    end
  end

  assign flag_mask = mask_for(with_carry);
endmodule

// File: rtl/mwadd_top.sv
module mwadd_top #(
  parameter int W_LONG   = 24,
  parameter int W_SHORT  = 16,
  parameter int HALF_BIT = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [W_LONG-1:0]  dst_val,
  input  logic [W_LONG-1:0]  src_pair,
  input  logic [W_LONG-1:0]  sp_long,
  input  logic [W_SHORT-1:0] sp_short,
  input  logic [1:0]         src_sel,
  input  logic               dst_index,
  input  logic               with_carry,
  input  logic               carry_in,
  input  logic               long_mode,
  input  logic [1:0]         ovr_code,
  output logic               out_valid,
  output logic               out_long,
  output logic [W_LONG-1:0]  result,
  output logic [7:0]         flags,
  output logic [7:0]         flag_mask
);
  import mwa_pkg::*;
  localparam int W_GAP = W_LONG - W_SHORT;

  logic              is_long;
  logic [W_LONG-1:0] keep_mask;
  logic [W_LONG-1:0] op_a, op_b, sum;
  logic              carry_out, half_carry, sign_ovf, res_msb, res_zero;
  logic [7:0]        nxt_flags, nxt_mask;
  logic              illegal_req, accept, cin_eff;
  logic              q_adc;

  assign illegal_req = with_carry & dst_index;
  assign accept      = in_valid & ~illegal_req;
  assign cin_eff     = with_carry & carry_in;

  mwa_width_sel #(.W_LONG(W_LONG), .W_SHORT(W_SHORT)) u_width (
    .long_mode (long_mode),
    .ovr_code  (ovr_code),
    .is_long   (is_long),
    .keep_mask (keep_mask)
  );

  mwa_opsel #(.W_LONG(W_LONG), .W_SHORT(W_SHORT)) u_opsel (
    .dst_val   (dst_val),
    .src_pair  (src_pair),
    .sp_long   (sp_long),
    .sp_short  (sp_short),
    .src_sel   (src_sel),
    .is_long   (is_long),
    .keep_mask (keep_mask),
    .op_a      (op_a),
    .op_b      (op_b)
  );

  mwa_arith #(.W_LONG(W_LONG), .W_SHORT(W_SHORT), .HALF_BIT(HALF_BIT)) u_arith (
    .op_a       (op_a),
    .op_b       (op_b),
    .cin        (cin_eff),
    .is_long    (is_long),
    .keep_mask  (keep_mask),
    .sum        (sum),
    .carry_out  (carry_out),
    .half_carry (half_carry),
    .sign_ovf   (sign_ovf),
    .res_msb    (res_msb),
    .res_zero   (res_zero)
  );

  mwa_flagpack u_flags (
    .with_carry (with_carry),
    .half_carry (half_carry),
    .carry_out  (carry_out),
    .sign_ovf   (sign_ovf),
    .res_msb    (res_msb),
    .res_zero   (res_zero),
    .flags      (nxt_flags),
    .flag_mask  (nxt_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_long  <= 1'b0;
      result    <= '0;
      flags     <= '0;
      flag_mask <= '0;
      q_adc     <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_long  <= is_long;
        result    <= sum;
        flags     <= nxt_flags;
        flag_mask <= nxt_mask;
        q_adc     <= with_carry;
      end
    end
  end

  AST_REJECT_ADC_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && with_carry && dst_index) |=> !out_valid); // R12
  AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(with_carry && dst_index)) |=> out_valid); // R13
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R13
  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_long) |-> (result[W_LONG-1:W_SHORT] == {W_GAP{1'b0}})); // R2
  AST_N_ALWAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags[FLG_N] == 1'b0 && flags[5] == 1'b0 && flags[3] == 1'b0)); // R8
  AST_ADD_KEEPS_SZPV: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !q_adc) |-> (flag_mask[FLG_S] == 1'b0 && flag_mask[FLG_Z] == 1'b0 && flag_mask[FLG_PV] == 1'b0)); // R5
  AST_ADC_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_adc) |-> (flags[FLG_Z] == (result == '0))); // R6
  AST_WIDTH_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(with_carry && dst_index) && ovr_code == OVR_LONG) |=> out_long); // R1
endmodule

// File: tb/tb_mwadd_top.sv
`timescale 1ns/1ps
module tb_mwadd_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] dst_val = '0, src_pair = '0, sp_long = '0;
  logic [15:0] sp_short = '0;
  logic [1:0]  src_sel = '0, ovr_code = '0;
  logic        dst_index = 1'b0, with_carry = 1'b0, carry_in = 1'b0, long_mode = 1'b0;
  logic        out_valid, out_long;
  logic [23:0] result;
  logic [7:0]  flags, flag_mask;

  typedef struct packed {
    logic        lng;
    logic [23:0] res;
    logic [7:0]  flg;
    logic [7:0]  msk;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;

  always #2.5 clk = ~clk;

  mwadd_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_val(dst_val),
    .src_pair(src_pair), .sp_long(sp_long), .sp_short(sp_short),
    .src_sel(src_sel), .dst_index(dst_index), .with_carry(with_carry),
    .carry_in(carry_in), .long_mode(long_mode), .ovr_code(ovr_code),
    .out_valid(out_valid), .out_long(out_long), .result(result),
    .flags(flags), .flag_mask(flag_mask)
  );

  // Reference model: integer arithmetic on the requirement text
  function automatic exp_t model(input logic [23:0] d, input logic [23:0] s,
                                 input logic [23:0] spl, input logic [15:0] sps,
                                 input logic [1:0] sel, input logic cin,
                                 input logic wc, input logic mode, input logic [1:0] ovr);
    exp_t   e;
    bit     lng;
    longint lim, a, b, c, t, r, sa, sb, ss;
    bit     cy, hc, ov;
    lng = (ovr == 2'b10) ? 1'b1 : (ovr == 2'b01) ? 1'b0 : mode;           // R1
    lim = lng ? 64'd16777216 : 64'd65536;
    a = longint'(d) % lim;
    if (sel == 2'b01)      b = a;                                          // R11
    else if (sel == 2'b10) b = lng ? longint'(spl) : longint'(sps);        // R10
    else                   b = longint'(s) % lim;
    c  = wc ? longint'(cin) : 0;                                           // R9
    t  = a + b + c;
    r  = t % lim;                                                          // R2
    cy = (t >= lim);                                                       // R3
    hc = ((a % 4096) + (b % 4096) + c) >= 4096;                            // R4
    sa = (a >= lim / 2) ? a - lim : a;
    sb = (b >= lim / 2) ? b - lim : b;
    ss = sa + sb + c;
    ov = (ss >= lim / 2) || (ss < -(lim / 2));                             // R7
    e.lng = lng;
    e.res = 24'(r);
    e.flg = '0;
    e.flg[4] = hc;
    e.flg[0] = cy;
    if (wc) begin                                                          // R6
      e.flg[7] = (r >= lim / 2);
      e.flg[6] = (r == 0);
      e.flg[2] = ov;
      e.msk = 8'hD7;
    end else begin
      e.msk = 8'h13;                                                       // R5
    end
    return e;
  endfunction

  task automatic send(input logic [23:0] d, input logic [23:0] s,
                      input logic [23:0] spl, input logic [15:0] sps,
                      input logic [1:0] sel, input logic cin, input logic wc,
                      input logic idx, input logic mode, input logic [1:0] ovr,
                      input string tag);
    @(negedge clk);
    in_valid = 1'b1; dst_val = d; src_pair = s; sp_long = spl; sp_short = sps;
    src_sel = sel; carry_in = cin; with_carry = wc; dst_index = idx;
    long_mode = mode; ovr_code = ovr;
    if (!(wc && idx)) begin
      exp_q.push_back(model(d, s, spl, sps, sel, cin, wc, mode, ovr));
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic check(input bit ok, input string what, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  // Monitor: pops the oldest expected item on every result strobe
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R12/R13 unexpected out_valid", 1, 0);
        end else begin
          exp_t  e;
          string tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          n_cmp++;
          if (result !== e.res || flags !== e.flg || flag_mask !== e.msk || out_long !== e.lng) begin
            n_bad++;
            $display("FAIL %s actual res=%06h flg=%02h msk=%02h long=%0b expected res=%06h flg=%02h msk=%02h long=%0b",
                     tg, result, flags, flag_mask, out_long, e.res, e.flg, e.msk, e.lng);
          end
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && result == '0 && flags == '0 && flag_mask == '0,
          "R13 reset state", {out_valid, result}, 0);
    rst_n = 1'b1;
    idle(2);

    // Signed boundaries at both widths (R7, R3)
    send(24'h007FFF, 24'h000001, 0, 0, 2'b00, 0, 1, 0, 0, 2'b00, "R7 16b 7FFF+1");
    send(24'h008000, 24'h008000, 0, 0, 2'b00, 0, 1, 0, 0, 2'b00, "R7 R3 16b 8000+8000");
    send(24'h7FFFFF, 24'h000001, 0, 0, 2'b00, 0, 1, 0, 1, 2'b00, "R7 24b 7FFFFF+1");
    send(24'h800000, 24'h800000, 0, 0, 2'b00, 0, 1, 0, 1, 2'b00, "R7 R3 24b 800000+800000");
    send(24'h00FFFF, 24'h000000, 0, 0, 2'b00, 1, 1, 0, 0, 2'b00, "R6 R9 16b zero via carry");
    // Half carry from bit 11 at both widths
    send(24'h000FFF, 24'h000001, 0, 0, 2'b00, 0, 0, 0, 0, 2'b00, "R4 16b half carry");
    send(24'h000FFF, 24'h000001, 0, 0, 2'b00, 0, 0, 0, 1, 2'b00, "R4 24b half carry");
    // Plain add: carry_in ignored, S Z PV untouched, upper byte masked
    send(24'hAB7FFF, 24'h000001, 0, 0, 2'b00, 1, 0, 0, 0, 2'b00, "R5 R9 R2 plain add");
    send(24'h00FFFF, 24'h000001, 0, 0, 2'b00, 1, 0, 1, 0, 2'b00, "R3 R8 index plain add");
    // Overrides against the mode bit
    send(24'h12FFFF, 24'h000001, 0, 0, 2'b00, 0, 0, 0, 1, 2'b01, "R1 short override");
    send(24'h12FFFF, 24'h000001, 0, 0, 2'b00, 0, 0, 0, 0, 2'b10, "R1 long override");
    send(24'h12FFFF, 24'h000001, 0, 0, 2'b00, 0, 0, 0, 1, 2'b11, "R1 override 11 follows mode");
    // Stack pointer selection and doubling
    send(24'h001000, 24'hFFFFFF, 24'h345678, 16'h2222, 2'b10, 0, 0, 0, 1, 2'b00, "R10 long sp");
    send(24'h001000, 24'hFFFFFF, 24'h345678, 16'h2222, 2'b10, 0, 0, 0, 1, 2'b01, "R10 short sp");
    send(24'h400001, 24'h123456, 0, 0, 2'b01, 0, 0, 1, 1, 2'b00, "R11 double 24b");
    send(24'h88C001, 24'h123456, 0, 0, 2'b01, 0, 1, 0, 0, 2'b00, "R11 double 16b adc");
    send(24'h000010, 24'h000020, 0, 0, 2'b11, 0, 0, 0, 0, 2'b00, "R11 sel 11 is pair");
    idle(3);

    // Rejected request (R12)
    send(24'h000001, 24'h000001, 0, 0, 2'b00, 0, 1, 1, 0, 2'b00, "R12");
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R12 adc to index rejected", out_valid, 0);
    idle(2);

    // Random traffic, back to back, all modes and overrides
    for (int i = 0; i < 600; i++) begin
      logic wc, idx;
      wc  = 1'($urandom);
      idx = wc ? 1'b0 : 1'($urandom);
      send(24'($urandom), 24'($urandom), 24'($urandom), 16'($urandom),
           2'($urandom), 1'($urandom), wc, idx, 1'($urandom), 2'($urandom),
           "R1 R2 R3 R4 R6 R7 random");
    end
    idle(4);
    check(exp_q.size() == 0, "R13 all results delivered", exp_q.size(), 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule